// File: doc/BRIEF.md
# Demultiplexing State Capture Front End

This block turns a wide probe bus into stored state records. The records are paced by a small group of external clock lines. Each clock line, the probe bus included, is brought into a fast internal clock domain through a two-flop synchronizer. An edge on a line is found by comparing its synchronized value with the value one cycle older. Each line can be set to contribute its rising edge, its falling edge, either edge, or nothing. The contributions are OR'ed into a capture qualifier. The probe word is taken from the same pipeline stage as the detected edge.

With demultiplexing enabled, a second qualifier (the slave qualifier) copies the low group of channels into a holding register. The number of channels in that group is configurable. A later master event then writes one combined word to a capture-memory write port: the held low channels plus the live upper channels. This splits a bus that carries address and data on the same pins into separate columns of one record. Default edge assignments apply unless custom assignments are selected. A write strobe and a wrapping write address come with every stored record.

Top module: `capdemux_top`

## Requirements
- R1: The capture qualifier is the OR of the edge events of all enabled clock lines. A master event on any enabled line produces exactly one write.
- R2: Each line i takes a 2-bit edge code in bits [2i+1:2i] of an edge vector. The codes are 00 = off, 01 = rising, 10 = falling, 11 = either edge. Line 0 is J, line 1 is K and line 2 is L.
- R3: With cfg_custom = 0 and demultiplexing off, writes occur on the rising edge of line 0 (J) only. Falling J edges and edges on K and L are ignored.
- R4: With demultiplexing on, a slave event loads the channels below the slave count into the holding register and produces no write. With demultiplexing off, slave events have no effect.
- R5: With demultiplexing on, a master event writes a record. Bit i of the record comes from the holding register when i < cfg_slave_cnt and from the live sample otherwise. With demultiplexing off, the record is the live sample.
- R6: cfg_slave_cnt selects the split at any value from 0 to NCH. A value above NCH takes every channel from the holding register. Splits of 27 and 18 out of 43 channels are supported.
- R7: With demultiplexing on and cfg_custom = 0, the slave qualifier is the falling edge of J and the master qualifier is the rising edge of J. With cfg_custom = 1, cfg_slave_edge and cfg_master_edge are used.
- R8: A master event that comes before any slave event since reset or since demultiplexing was enabled still writes a record. That record has wr_hold_valid = 0 and zero held bits. Disabling demultiplexing clears the holding register.
- R9: When slave and master events fall in the same cycle, the holding register is updated first and its new value is the one written.
- R10: wr_en is high for one cycle per record. wr_addr starts at 0, increases by one per record and wraps from DEPTH-1 to 0.
- R11: After reset, wr_en, wr_addr, wr_data and wr_hold_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_in | input | NCH | Probe channels |
| clk_lines | input | NCLK | External clock lines (0 = J, 1 = K, 2 = L) |
| cfg_mux_en | input | 1 | Demultiplexing enable |
| cfg_custom | input | 1 | Use configured edge vectors instead of the defaults |
| cfg_master_edge | input | 2*NCLK | Master/capture edge codes per line |
| cfg_slave_edge | input | 2*NCLK | Slave edge codes per line |
| cfg_slave_cnt | input | $clog2(NCH+1) | Number of low channels taken by the slave phase |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | AW | Write address |
| wr_data | output | NCH | Record to store |
| wr_hold_valid | output | 1 | Held bits of this record were loaded by a slave event |

## Verification
The bench builds the block with NCH = 43, three clock lines and DEPTH = 5. The 43-channel width lets both the 27-channel and the 18-channel splits be exercised against hand-merged records. The small depth brings the address wrap within reach after a few records, and the bench checks that wrap on every write. The three lines allow OR combinations, every edge code on each line, the default edge assignments and a same-cycle slave/master collision to be driven directly.

// File: rtl/cdx_pkg.sv
package cdx_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_sel_e;
endpackage

// File: rtl/cdx_sync.sv
module cdx_sync #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_sync,
   output logic [W-1:0] d_prev
);
   logic [W-1:0] meta_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         d_sync <= '0;
         d_prev <= '0;
      end else begin
         meta_q <= d_in;
         d_sync <= meta_q;
         d_prev <= d_sync;
      end
   end
endmodule

// File: rtl/cdx_qual.sv
module cdx_qual
   import cdx_pkg::*;
#(
   parameter int NCLK = 3
) (
   input  logic [NCLK-1:0]   cur,
   input  logic [NCLK-1:0]   prev,
   input  logic [2*NCLK-1:0] sel,
   output logic              fire
);
   logic [NCLK-1:0] hit;

   for (genvar i = 0; i < NCLK; i++) begin : g_line
      logic rise_w, fall_w;
      assign rise_w = cur[i] & ~prev[i];
      assign fall_w = ~cur[i] & prev[i];
      always_comb begin
         case (edge_sel_e'(sel[2*i +: 2]))
            EDGE_RISE: hit[i] = rise_w;
            EDGE_FALL: hit[i] = fall_w;
            EDGE_ANY:  hit[i] = rise_w | fall_w;
            default:   hit[i] = 1'b0;
         endcase
      end
   end

   assign fire = |hit;
endmodule

// File: rtl/cdx_hold.sv
module cdx_hold #(
   parameter int NCH = 43,
   parameter int CW  = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mux_en,
   input  logic           slave_ev,
   input  logic [NCH-1:0] live,
   input  logic [CW-1:0]  scnt,
   output logic [NCH-1:0] merged,
   output logic           merged_valid
);
   logic [NCH-1:0] low_mask;
   logic [NCH-1:0] hold_q, hold_d;
   logic           valid_q, valid_d;

   for (genvar i = 0; i < NCH; i++) begin : g_mask
      assign low_mask[i] = (scnt > CW'(i));
   end

   always_comb begin
      hold_d  = slave_ev ? (live & low_mask) : hold_q;
      valid_d = mux_en & (slave_ev | valid_q);
      if (mux_en) merged = (hold_d & low_mask) | (live & ~low_mask);
      else        merged = live;
      merged_valid = valid_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         valid_q <= 1'b0;
      end else if (!mux_en) begin
         hold_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         hold_q  <= hold_d;
         valid_q <= valid_d;
      end
   end

   AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mux_en && !slave_ev) |=> (hold_q == $past(hold_q) || !$past(mux_en))); // R4
   AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !mux_en |=> !valid_q); // R8
endmodule

// File: rtl/cdx_waddr.sv
module cdx_waddr #(
   parameter int DEPTH = 1024,
   parameter int AW    = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr <= '0;
      else if (fire)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST); // R10
   AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(ptr)); // R10
endmodule

// File: rtl/capdemux_top.sv
module capdemux_top
   import cdx_pkg::*;
#(
   parameter int NCH   = 43,
   parameter int NCLK  = 3,
   parameter int DEPTH = 1024,
   localparam int CW   = $clog2(NCH + 1),
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    probe_in,
   input  logic [NCLK-1:0]   clk_lines,
   input  logic              cfg_mux_en,
   input  logic              cfg_custom,
   input  logic [2*NCLK-1:0] cfg_master_edge,
   input  logic [2*NCLK-1:0] cfg_slave_edge,
   input  logic [CW-1:0]     cfg_slave_cnt,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [NCH-1:0]    wr_data,
   output logic              wr_hold_valid
);
   if (NCH < 2)    begin : g_bad_nch   $error("NCH must be at least 2");   end
   if (NCLK < 1)   begin : g_bad_nclk  $error("NCLK must be at least 1");  end
   if (DEPTH < 2)  begin : g_bad_depth $error("DEPTH must be at least 2"); end

   localparam logic [2*NCLK-1:0] DEF_MASTER = (2*NCLK)'(EDGE_RISE);
   localparam logic [2*NCLK-1:0] DEF_SLAVE  = (2*NCLK)'(EDGE_FALL);

   logic [NCLK-1:0]   ck_cur, ck_prev;
   logic [NCH-1:0]    live, live_prev_unused;
   logic [2*NCLK-1:0] m_sel, s_sel;
   logic              m_fire, s_fire, slave_ev;
   logic [NCH-1:0]    merged;
   logic              merged_valid;
   logic [AW-1:0]     ptr;

   cdx_sync #(.W(NCLK)) u_ck_sync (
      .clk(clk), .rst_n(rst_n), .d_in(clk_lines), .d_sync(ck_cur), .d_prev(ck_prev));
   cdx_sync #(.W(NCH)) u_data_sync (
      .clk(clk), .rst_n(rst_n), .d_in(probe_in), .d_sync(live), .d_prev(live_prev_unused));

   assign m_sel = cfg_custom ? cfg_master_edge : DEF_MASTER;
   assign s_sel = cfg_custom ? cfg_slave_edge  : DEF_SLAVE;

   cdx_qual #(.NCLK(NCLK)) u_master_q (
      .cur(ck_cur), .prev(ck_prev), .sel(m_sel), .fire(m_fire));
   cdx_qual #(.NCLK(NCLK)) u_slave_q (
      .cur(ck_cur), .prev(ck_prev), .sel(s_sel), .fire(s_fire));

   assign slave_ev = cfg_mux_en & s_fire;

   cdx_hold #(.NCH(NCH), .CW(CW)) u_hold (
      .clk(clk), .rst_n(rst_n), .mux_en(cfg_mux_en), .slave_ev(slave_ev),
      .live(live), .scnt(cfg_slave_cnt), .merged(merged), .merged_valid(merged_valid));

   cdx_waddr #(.DEPTH(DEPTH), .AW(AW)) u_waddr (
      .clk(clk), .rst_n(rst_n), .fire(m_fire), .ptr(ptr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en         <= 1'b0;
         wr_addr       <= '0;
         wr_data       <= '0;
         wr_hold_valid <= 1'b0;
      end else begin
         wr_en <= m_fire;
         if (m_fire) begin
            wr_addr       <= ptr;
            wr_data       <= merged;
            wr_hold_valid <= merged_valid;
         end
      end
   end

   AST_MASTER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      m_fire |=> wr_en); // R1
   AST_SLAVE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_ev && !m_fire) |=> !wr_en); // R4
   AST_NONMUX_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_fire && !cfg_mux_en) |=> !wr_hold_valid); // R8
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en) && $past(rst_n)) |->
         (wr_addr == (($past(wr_addr) == AW'(DEPTH-1)) ? '0 : $past(wr_addr) + 1'b1))); // R10
endmodule

// File: tb/sim_capdemux_top.sv
module sim_capdemux_top;
   localparam int NCH = 43, NCLK = 3, DEPTH = 5;
   localparam int CW = $clog2(NCH + 1);
   localparam int AW = $clog2(DEPTH);
   localparam logic [NCH-1:0] D1 = 43'h123_4567_89AB;
   localparam logic [NCH-1:0] D2 = 43'h3DC_BA98_7654;
   localparam logic [NCH-1:0] D3 = 43'h0FF_00FF_00FF;
   localparam logic [NCH-1:0] D4 = 43'h2A5_5A5A_5A5A;

   logic clk = 0, rst_n = 0;
   logic [NCH-1:0] probe = '0;
   logic [NCLK-1:0] clines = '0;
   logic mux_en = 0, custom = 0;
   logic [2*NCLK-1:0] m_edge = '0, s_edge = '0;
   logic [CW-1:0] scnt = CW'(27);
   logic wr_en, wr_hold_valid;
   logic [AW-1:0] wr_addr;
   logic [NCH-1:0] wr_data;

   int checks = 0, fails = 0, nlog = 0, seen = 0, exp_addr = 0;
   logic [NCH-1:0] log_data [256];
   logic [AW-1:0]  log_addr [256];
   logic           log_hv   [256];
   bit done = 0;

   always #4 clk = ~clk;

   capdemux_top #(.NCH(NCH), .NCLK(NCLK), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .probe_in(probe), .clk_lines(clines),
      .cfg_mux_en(mux_en), .cfg_custom(custom), .cfg_master_edge(m_edge),
      .cfg_slave_edge(s_edge), .cfg_slave_cnt(scnt), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_hold_valid(wr_hold_valid));

   always @(negedge clk) if (rst_n && wr_en && nlog < 256) begin
      log_data[nlog] = wr_data;
      log_addr[nlog] = wr_addr;
      log_hv[nlog]   = wr_hold_valid;
      nlog++;
   end

   task automatic chk(input bit ok, input string what, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   function automatic logic [NCH-1:0] mix(input logic [NCH-1:0] h, input logic [NCH-1:0] l, input int n);
      logic [NCH-1:0] r;
      for (int i = 0; i < NCH; i++) r[i] = (i < n) ? h[i] : l[i];
      return r;
   endfunction

   task automatic drive(input logic [NCLK-1:0] lines, input logic [NCH-1:0] d);
      @(negedge clk);
      clines = lines;
      probe  = d;
      repeat (6) @(negedge clk);
   endtask

   task automatic expect_write(input logic [NCH-1:0] exp, input bit hv, input string what);
      chk(nlog == seen + 1, {what, " write count"}, NCH'(nlog - seen), NCH'(1));
      if (nlog == seen + 1) begin
         chk(log_data[seen] == exp, {what, " data"}, log_data[seen], exp);
         chk(log_hv[seen] == hv, {what, " hold valid"}, NCH'(log_hv[seen]), NCH'(hv));
         chk(log_addr[seen] == AW'(exp_addr), {what, " address R10"}, NCH'(log_addr[seen]), NCH'(exp_addr));
         exp_addr = (exp_addr + 1) % DEPTH;
      end
      seen = nlog;
   endtask

   task automatic expect_none(input string what);
      chk(nlog == seen, {what, " no write"}, NCH'(nlog - seen), NCH'(0));
      seen = nlog;
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk(wr_en == 0 && wr_addr == 0 && wr_data == 0 && wr_hold_valid == 0,
          "R11 reset outputs", wr_data, '0);
      rst_n = 1;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_default_edge;
      drive(3'b001, D1); expect_write(D1, 0, "R3 J rise");
      drive(3'b000, D2); expect_none("R3 J fall ignored");
      drive(3'b010, D3); expect_none("R3 K rise ignored");
      drive(3'b110, D3); expect_none("R3 L rise ignored");
      drive(3'b000, D3); expect_none("R3 K L fall ignored");
   endtask

   task automatic t_custom_or;
      custom = 1;
      m_edge = 6'b01_10_00;      // L rise, K fall
      s_edge = 6'b00_00_01;      // slave J rise, mux off
      drive(3'b010, D2); expect_none("R2 K rise not selected");
      drive(3'b000, D3); expect_write(D3, 0, "R1 K fall");
      drive(3'b100, D4); expect_write(D4, 0, "R1 L rise");
      drive(3'b101, D1); expect_none("R4 J rise slave ignored without mux");
      m_edge = 6'b00_00_11;      // J either edge
      drive(3'b100, D2); expect_write(D2, 0, "R2 J either falling");
      drive(3'b101, D3); expect_write(D3, 0, "R2 J either rising");
      m_edge = 6'b00_00_00;
      drive(3'b000, D1); expect_none("R2 all off");
   endtask

   task automatic t_mux_default;
      custom = 0; scnt = CW'(27);
      @(negedge clk); mux_en = 1;
      drive(3'b001, D1); expect_write(mix('0, D1, 27), 0, "R8 master before slave");
      drive(3'b000, D2); expect_none("R4 R7 slave J fall no write");
      drive(3'b001, D3); expect_write(mix(D2, D3, 27), 1, "R5 R7 split 27");
      scnt = CW'(18);
      drive(3'b000, D4); expect_none("R4 slave 18");
      drive(3'b001, D1); expect_write(mix(D4, D1, 18), 1, "R6 split 18");
      scnt = CW'(0);
      drive(3'b000, D2); expect_none("R6 slave cnt 0");
      drive(3'b001, D3); expect_write(D3, 1, "R6 split 0 all live");
      scnt = CW'(63);
      drive(3'b000, D2); expect_none("R6 slave full");
      drive(3'b001, D4); expect_write(D2, 1, "R6 split above NCH all held");
      scnt = CW'(18);
   endtask

   task automatic t_same_cycle;
      custom = 1;
      m_edge = 6'b00_00_01;      // master J rise
      s_edge = 6'b00_01_00;      // slave K rise
      drive(3'b000, D2); expect_none("R9 setup");
      drive(3'b011, D3); expect_write(D3, 1, "R9 same cycle new hold");
   endtask

   task automatic t_reenable;
      @(negedge clk); mux_en = 0;
      drive(3'b000, D1); expect_none("R8 idle");
      @(negedge clk); mux_en = 1; custom = 0;
      drive(3'b001, D2); expect_write(mix('0, D2, 18), 0, "R8 re-enable clears hold");
   endtask

   task automatic t_wrap;
      @(negedge clk); mux_en = 0; custom = 1; m_edge = 6'b00_00_11;
      for (int k = 0; k < 7; k++) begin
         logic [NCH-1:0] d;
         d = D1 ^ NCH'(k * 7919);
         drive(clines ^ 3'b001, d);
         expect_write(d, 0, "R10 wrap sequence");
      end
   endtask

   initial begin
      t_reset;
      t_default_edge;
      t_custom_or;
      t_mux_default;
      t_same_cycle;
      t_reenable;
      t_wrap;
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule